// File: doc/BRIEF.md
# Translation Table Walker (4 KB granule)

This block converts a 48-bit virtual address into a physical address. It walks a tree of translation tables that sit in memory, with one 64-bit descriptor read per level. The requester supplies the virtual address, the physical base of the root table, the size field that removes unused top address bits, and a packed register that holds eight memory-attribute bytes. The walk starts at level 0, 1 or 2, depending on how many address bits are live. It can end early on a 1 GB or 2 MB block, or it can go down to a 4 KB page at level 3.

When the walk ends, the block reports the physical address, the mapping size, the selected attribute byte, the shareability bits and both execute-never flags. If the walk cannot complete, it reports a fault with the level at which it stopped. Memory is reached over a plain request/response port with at most one read in flight.

Top module: `pt_walker`

## Requirements
- R1: For a walk at level L (0 to 3), the table index is the 9 virtual-address bits starting at bit 12+9*(3-L): level 0 uses va[47:39], level 1 uses va[38:30], level 2 uses va[29:21] and level 3 uses va[20:12]. The descriptor read address is {table base[PA_W-1:12], index, 3'b000}.
- R2: The size field is first clamped to the range 16..39. Values below 25 start the walk at level 0, values 25..33 start it at level 1, and values 34..39 start it at level 2.
- R3: If any virtual-address bit at position 64-size or above is set, the block reports a fault at the start level and issues no memory read.
- R4: A descriptor with bit 0 clear is invalid and causes a fault at the current level.
- R5: A block descriptor (bits [1:0]=01) ends the walk. At level 1 it gives size code 2 (1 GB) and PA {d[PA_W-1:30], va[29:0]}. At level 2 it gives size code 1 (2 MB) and PA {d[PA_W-1:21], va[20:0]}.
- R6: A block encoding at level 0 or level 3 causes a fault at that level.
- R7: Bits [1:0]=11 at levels 0 to 2 make the next table base d[PA_W-1:12] and move the walk one level down. At level 3 the same encoding is a 4 KB page: size code 0 and PA {d[PA_W-1:12], va[11:0]}.
- R8: A block or page descriptor with the access flag (bit 10) clear causes a fault at that level.
- R9: The reported attribute is byte d[4:2] of the attribute register (bits [8*i+7:8*i]). Shareability is d[9:8].
- R10: The unprivileged execute-never output is d[54] OR'ed with bit 60 of every table descriptor passed on the way down. The privileged execute-never output is d[53] OR'ed with bit 59 of those table descriptors.
- R11: A read request lasts one cycle. No new read is issued until the previous response has arrived.
- R12: req_ready is high only while the block is idle. done_valid pulses for one cycle per request. On a fault, the PA, size, attribute, shareability and execute-never outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_va | input | 48 | Virtual address |
| req_base | input | PA_W | Physical address of the root table |
| cfg_tsz | input | 6 | Size field for the unused top address bits |
| cfg_attr | input | 64 | Eight packed attribute bytes |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | PA_W | Descriptor read address |
| mem_rsp_valid | input | 1 | Descriptor read data is valid |
| mem_rsp_data | input | 64 | Descriptor read data |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Translation fault |
| done_level | output | 2 | Level at which the walk ended |
| done_pa | output | PA_W | Physical address |
| done_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| done_attr | output | 8 | Selected attribute byte |
| done_sh | output | 2 | Shareability bits |
| done_uxn | output | 1 | Unprivileged execute-never |
| done_pxn | output | 1 | Privileged execute-never |

## Verification
The bench builds the block with PA_W = 32. With that setting, four 4 KB tables in a small bench memory can hold a complete tree. The bench sweeps every entry of a level-2 table and every entry of a level-3 table. The entries are filled with a repeating mix of blocks, table pointers, pages, invalid entries, entries with the access flag cleared and misplaced block encodings. Expected results and read counts come from an arithmetic walk of that memory. Size settings of 20, 24, 25, 32, 33, 34 and 36 reach all three start levels and their boundaries, and out-of-range addresses exercise the no-read fault path.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [47:0]     req_va,
  input  logic [PA_W-1:0] req_base,
  input  logic [5:0]      cfg_tsz,
  input  logic [63:0]     cfg_attr,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_fault,
  output logic [1:0]      done_level,
  output logic [PA_W-1:0] done_pa,
  output logic [1:0]      done_size,
  output logic [7:0]      done_attr,
  output logic [1:0]      done_sh,
  output logic            done_uxn,
  output logic            done_pxn
);
  localparam int TW = PA_W - 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [47:0]   va;
  logic [TW-1:0] tbl;
  logic [1:0]    lvl;
  logic          xu, xp;

  wire [5:0] tsz   = (cfg_tsz < 6'd16) ? 6'd16 : (cfg_tsz > 6'd39) ? 6'd39 : cfg_tsz;
  wire [6:0] top   = 7'd64 - {1'b0, tsz};
  wire       oor   = (req_va >> top) != 48'd0;
  wire [1:0] start = (tsz < 6'd25) ? 2'd0 : (tsz < 6'd34) ? 2'd1 : 2'd2;

  wire [5:0] ib  = 6'd12 + 6'd9 * (6'd3 - {4'd0, lvl});
  wire [8:0] idx = va[ib +: 9];

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = {tbl, idx, 3'b000};

  wire [63:0]   d    = mem_rsp_data;
  wire [TW-1:0] dout = d[PA_W-1:12];
  wire          blk  = (d[1:0] == 2'b01);
  wire          nxt  = (d[1:0] == 2'b11);
  wire          bad  = !d[0] || (blk && (lvl == 2'd0 || lvl == 2'd3));

  logic [PA_W-1:0] pa;
  always_comb begin
    case (lvl)
      2'd1:    pa = {dout[TW-1:18], va[29:0]};
      2'd2:    pa = {dout[TW-1:9],  va[20:0]};
      default: pa = {dout, va[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0; tbl <= '0; lvl <= '0; xu <= 1'b0; xp <= 1'b0;
      done_valid <= 1'b0; done_fault <= 1'b0; done_level <= '0;
      done_pa <= '0; done_size <= '0; done_attr <= '0; done_sh <= '0;
      done_uxn <= 1'b0; done_pxn <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_va; tbl <= req_base[PA_W-1:12]; lvl <= start;
          xu <= 1'b0; xp <= 1'b0;
          if (oor) begin
            done_valid <= 1'b1; done_fault <= 1'b1; done_level <= start;
            done_pa <= '0; done_size <= '0; done_attr <= '0; done_sh <= '0;
            done_uxn <= 1'b0; done_pxn <= 1'b0;
          end else st <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!bad && nxt && lvl != 2'd3) begin
            tbl <= dout; lvl <= lvl + 2'd1;
            xu <= xu | d[60]; xp <= xp | d[59];
            st <= S_REQ;
          end else begin
            st <= S_IDLE;
            done_valid <= 1'b1;
            done_level <= lvl;
            if (bad || !d[10]) begin
              done_fault <= 1'b1;
              done_pa <= '0; done_size <= '0; done_attr <= '0; done_sh <= '0;
              done_uxn <= 1'b0; done_pxn <= 1'b0;
            end else begin
              done_fault <= 1'b0;
              done_pa    <= pa;
              done_size  <= (lvl == 2'd3) ? 2'd0 : (lvl == 2'd2) ? 2'd1 : 2'd2;
              done_attr  <= cfg_attr[{d[4:2], 3'b000} +: 8];
              done_sh    <= d[9:8];
              done_uxn   <= xu | d[54];
              done_pxn   <= xp | d[53];
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            done_valid,
  input logic            done_fault,
  input logic [1:0]      done_level,
  input logic [PA_W-1:0] done_pa,
  input logic [1:0]      done_size
);
  logic busy_rd;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_rd <= 1'b0;
    else if (mem_req_valid) busy_rd <= 1'b1;
    else if (mem_rsp_valid) busy_rd <= 1'b0;
  end

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !busy_rd);
  assert_single_cycle_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_aligned_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  assert_idle_no_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);
  assert_fault_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_pa == '0 && done_size == 2'd0));
  assert_page_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault && done_size == 2'd0) |-> done_level == 2'd3);
  assert_block_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault && done_size != 2'd0) |-> (done_level == 2'd3 - done_size));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .done_valid(done_valid),
  .done_fault(done_fault), .done_level(done_level),
  .done_pa(done_pa), .done_size(done_size)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_P = 10;
  localparam int PA_W  = 32;
  localparam logic [63:0] ATTR = 64'h335AA5FF_440C0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [47:0] req_va = '0;
  logic [PA_W-1:0] req_base = '0;
  logic [5:0] cfg_tsz = 6'd32;
  logic [63:0] cfg_attr = ATTR;
  logic mem_req_valid, mem_rsp_valid = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data = '0;
  logic done_valid, done_fault, done_uxn, done_pxn;
  logic [1:0] done_level, done_size, done_sh;
  logic [PA_W-1:0] done_pa;
  logic [7:0] done_attr;

  int checks = 0, fails = 0, nreads = 0;
  logic [63:0] mem [0:2047];

  always #(CLK_P/2) clk = ~clk;

  pt_walker #(.PA_W(PA_W)) i_pt_walker (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    mem_rsp_data  <= mem[mem_req_addr[13:3]];
    if (mem_req_valid) nreads <= nreads + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    fails++; checks++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  logic e_f, e_u, e_p; logic [1:0] e_l, e_s, e_sh; logic [31:0] e_pa; logic [7:0] e_a; int e_n;

  task automatic ref_walk(input logic [47:0] va, input logic [5:0] tz, input logic [31:0] base);
    int t, lv; logic [31:0] tb; logic [63:0] d; logic fin, u, p; int ix;
    t = (tz < 16) ? 16 : (tz > 39) ? 39 : tz;
    lv = (t < 25) ? 0 : (t < 34) ? 1 : 2;
    e_f = 1; e_l = lv[1:0]; e_pa = 0; e_s = 0; e_a = 0; e_sh = 0; e_u = 0; e_p = 0; e_n = 0;
    if ((va >> (64 - t)) != 0) return;
    tb = base; u = 0; p = 0; fin = 0;
    for (int n = 0; n < 4 && !fin; n++) begin
      ix = int'((va >> (12 + 9 * (3 - lv))) & 48'h1FF);
      d = mem[((tb + ix * 8) >> 3) & 2047];
      e_n++; e_l = lv[1:0];
      if (d[0] == 0 || (d[1:0] == 2'b01 && (lv == 0 || lv == 3))) fin = 1;
      else if (d[1] && lv < 3) begin
        tb = {d[31:12], 12'h0}; u |= d[60]; p |= d[59]; lv++;
      end else begin
        fin = 1;
        if (d[10]) begin
          logic [31:0] m;
          m = (lv == 1) ? 32'h3FFF_FFFF : (lv == 2) ? 32'h001F_FFFF : 32'h0000_0FFF;
          e_f = 0; e_pa = (d[31:0] & ~m & 32'hFFFF_F000) | (va[31:0] & m);
          e_s = 2'(3 - lv); e_a = ATTR[8*d[4:2] +: 8]; e_sh = d[9:8];
          e_u = u | d[54]; e_p = p | d[53];
        end
      end
    end
  endtask

  task automatic run(input logic [47:0] va, input logic [5:0] tz, input logic [31:0] base, input string req);
    int w = 0;
    ref_walk(va, tz, base);
    @(negedge clk);
    req_va = va; cfg_tsz = tz; req_base = base; req_valid = 1'b1;
    nreads = 0;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!done_valid && w < 60) begin @(negedge clk); w++; end
    checks++;
    if (!done_valid || done_fault !== e_f || done_level !== e_l || done_pa !== e_pa ||
        done_size !== e_s || done_attr !== e_a || done_sh !== e_sh ||
        done_uxn !== e_u || done_pxn !== e_p || nreads != e_n) begin
      fails++;
      $display("FAIL %s va=%h tsz=%0d actual f%0b l%0d pa%h s%0d a%h sh%0d x%0b%0b rd%0d expected f%0b l%0d pa%h s%0d a%h sh%0d x%0b%0b rd%0d",
        req, va, tz, done_fault, done_level, done_pa, done_size, done_attr, done_sh, done_uxn, done_pxn, nreads,
        e_f, e_l, e_pa, e_s, e_a, e_sh, e_u, e_p, e_n);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0] = 64'h401;
    mem[1] = 64'h4000_0711;
    mem[2] = 64'h1000_0000_0000_1003;
    for (int j = 0; j < 512; j++) begin
      case (j % 4)
        1: mem[512+j] = (64'((j * 7) % 2048) << 21) | (64'(j % 8) << 2) | (64'(j % 3) << 8) |
                        64'h401 | (64'(j % 8 == 5) << 54) | (64'(j % 16 == 9) << 53);
        2: mem[512+j] = 64'h2003 | (64'(j % 8 == 6) << 59);
        3: mem[512+j] = (64'(j) << 21) | 64'h1;
        default: mem[512+j] = '0;
      endcase
      case (j % 4)
        0: mem[1024+j] = (64'((j * 13) % 1048576) << 12) | 64'h403 | (64'(j % 8) << 2) |
                         (64'((j / 4) % 4) << 8) | (64'(j % 8 == 4) << 53) | (64'(j % 16 == 8) << 54);
        1: mem[1024+j] = 64'h401;
        2: mem[1024+j] = '0;
        default: mem[1024+j] = (64'(j) << 12) | 64'h3;
      endcase
    end
    mem[1536] = 64'h3;
    mem[1537] = 64'h401;

    repeat (3) @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || done_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
      fails++; $display("FAIL R12 reset state actual rdy=%0b dv=%0b mr=%0b expected 1 0 0", req_ready, done_valid, mem_req_valid);
    end
    rst_n = 1'b1;

    // R5 R9 R4: level-1 entries from the root table
    for (int e = 0; e < 4; e++) run((48'(e) << 30) | 48'h123, 6'd32, 32'h0, "R5_R9_R4_l1");
    // R1 R5 R6 R7 R8 R10: sweep all level-2 entries
    for (int j = 0; j < 512; j++)
      run((48'd2 << 30) | (48'(j) << 21) | (48'(j) << 12) | 48'((j * 3) % 4096), 6'd32, 32'h0, "R1_R5_R8_R10_l2");
    // R6 R7 R8 R9 R10: sweep all level-3 entries below a table with bit 59
    for (int k = 0; k < 512; k++)
      run((48'd2 << 30) | (48'd6 << 21) | (48'(k) << 12) | 48'(k * 5), 6'd32, 32'h0, "R6_R7_R10_l3");
    // R2: start at level 2
    for (int j = 0; j < 128; j++)
      run((48'(j) << 21) | (48'(j) << 12) | 48'h77, 6'd36, 32'h1000, "R2_start2");
    run((48'd5 << 21) | 48'h1, 6'd34, 32'h1000, "R2_tsz34");
    // R2 R6: start at level 0
    run((48'd1 << 30) | 48'h9, 6'd20, 32'h3000, "R2_start0");
    run((48'd1 << 39), 6'd20, 32'h3000, "R6_l0_block");
    run((48'd1 << 30) | 48'h5, 6'd24, 32'h3000, "R2_tsz24");
    run((48'd1 << 30) | 48'h5, 6'd25, 32'h0, "R2_tsz25");
    run((48'd1 << 30) | 48'h5, 6'd33, 32'h0, "R2_tsz33");
    // R3: out-of-range addresses
    run(48'h1_0000_0000, 6'd32, 32'h0, "R3_oor32");
    run(48'h0_1000_0000, 6'd36, 32'h1000, "R3_oor36");
    run(48'h1000_0000_0000, 6'd20, 32'h3000, "R3_oor20");
    run(48'h80_0000_0000, 6'd25, 32'h0, "R3_oor25");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule